// File: doc/BRIEF.md
# Enclave-Aware Performance Counter Gating

This block owns a small bank of per-thread event counters and decides, cycle by cycle, which of them may accumulate. The decision depends on the protected-enclave state of the local thread and of its sibling thread. It does not depend on a plain enable bit. Each thread's state is tracked from entry and exit strobes, and each entry carries a flag that says whether the enclave forbids observation (opt-out) or permits it (opt-in).

While the local thread executes opt-out enclave code, these counters freeze:
- the general-purpose counters;
- fixed counter 0.

Fixed counters 1 and 2 count cycles, so they keep running. A sampling-suppress output tells the precise-sample record logic to stay quiet, and a sticky bit in a 64-bit global status word records that suppression happened.

While the sibling thread runs opt-out code, any counter configured to also count the sibling's events is demoted to counting only its own thread's events. The counter is promoted back when the sibling leaves.

Counter values are exposed directly, together with one-cycle wrap pulses. The overflow pulses are meant for the interrupt and record-writing logic, which lives elsewhere.

Top module: `pmc_enclave_gate`

## Requirements
- R1: From the cycle after a local entry strobe with the opt-out flag set, every general-purpose counter and fixed counter 0 hold their value regardless of event inputs.
- R2: Fixed counters 1 and 2 keep adding their events while the local thread is in opt-out mode.
- R3: `sample_suppress` is 1 exactly in the cycles after an opt-out entry strobe and up to and including the cycle of the next exit or opt-in entry strobe; it is 0 otherwise.
- R4: Suppression sets bit 60 of `global_status`; all other bits of `global_status` are always 0.
- R5: Bit 60 stays set until a `status_clr` strobe arrives while the thread is neither suppressed nor entering opt-out; a clear in the same cycle as suppression leaves the bit set.
- R6: A counter adds 1 for its own-thread event and, when its any-thread bit is 1, another 1 for the sibling-thread event in the same cycle (an increment of up to 2).
- R7: While the sibling thread is in opt-out mode, any-thread counters ignore sibling events; after the sibling's exit strobe, sibling events count again from the next cycle.
- R8: Either a normal exit strobe (`local_exit`) or an asynchronous exit strobe (`local_aex`) ends local suppression from the next cycle.
- R9: An opt-in entry does not stop any counter and does not raise `sample_suppress`.
- R10: Counters are `CNT_W` bits wide (default 48). A counter wraps to zero, and its overflow bit is 1 for exactly the cycle after the wrap edge.
- R11: An entry strobe and an exit strobe in the same cycle act as exit followed by entry, so the mode of the new entry takes effect.
- R12: After reset, all counters are 0, `global_status` is 0, `sample_suppress` is 0 and no overflow bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| local_enter | input | 1 | Local thread enclave entry strobe |
| local_enter_optout | input | 1 | Entry is opt-out (1) or opt-in (0) |
| local_exit | input | 1 | Local normal exit strobe |
| local_aex | input | 1 | Local asynchronous exit strobe |
| sib_enter | input | 1 | Sibling thread entry strobe |
| sib_enter_optout | input | 1 | Sibling entry is opt-out |
| sib_exit | input | 1 | Sibling exit strobe (any kind) |
| gp_evt_own | input | NUM_GP | Own-thread event pulses, general-purpose counters |
| gp_evt_sib | input | NUM_GP | Sibling-thread event pulses, general-purpose counters |
| gp_anythr | input | NUM_GP | Any-thread configuration bits, general-purpose counters |
| fx_evt_own | input | 3 | Own-thread event pulses, fixed counters |
| fx_evt_sib | input | 3 | Sibling-thread event pulses, fixed counters |
| fx_anythr | input | 3 | Any-thread configuration bits, fixed counters |
| status_clr | input | 1 | Clear strobe for the suppression status bit |
| gp_count | output | NUM_GP x CNT_W | General-purpose counter values |
| fx_count | output | 3 x CNT_W | Fixed counter values |
| gp_ovf | output | NUM_GP | One-cycle wrap pulses, general-purpose counters |
| fx_ovf | output | 3 | One-cycle wrap pulses, fixed counters |
| sample_suppress | output | 1 | Precise-sample record generation must be held off |
| global_status | output | 64 | Global status word, bit 60 = suppression seen |

## Verification
The assertions assume the following about the inputs:
- Strobes and event pulses are synchronous and settled before the clock edge.
- The exit strobe only ends a stay that actually began. For the wrap-pulse property, a counter cannot wrap twice within two cycles, which holds for any width of two or more.

The bench drives every input at the falling edge and holds each strobe for exactly one cycle. It only exits after an entry, except where it deliberately pairs entry and exit in one cycle. It shrinks the counter width so that a wrap takes a few hundred events instead of an unreachable count.

// File: rtl/pmc_gate_pkg.sv
package pmc_gate_pkg;

    localparam int STATUS_W = 64;
    localparam int SUPP_BIT = 60;
    localparam int NUM_FIX  = 3;

    typedef enum logic [1:0] {
        ENC_OUT    = 2'd0,
        ENC_OPTIN  = 2'd1,
        ENC_OPTOUT = 2'd2
    } enc_mode_e;

    typedef struct packed {
        logic enter;
        logic optout;
        logic leave;
    } enc_cmd_t;

    // Exit is applied first, then entry, so an entry in the same cycle wins.
    function automatic enc_mode_e next_mode(enc_mode_e cur, enc_cmd_t c);
        enc_mode_e m;
        m = cur;
        if (c.leave) m = ENC_OUT;
        if (c.enter) m = c.optout ? ENC_OPTOUT : ENC_OPTIN;
        return m;
    endfunction

    function automatic logic [1:0] evt_incr(logic own, logic sib, logic any_ok);
        return {1'b0, own} + {1'b0, sib & any_ok};
    endfunction

endpackage

// File: rtl/pmc_mode_track.sv
module pmc_mode_track
    import pmc_gate_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  enc_cmd_t cmd,
    output logic     optout
);

    enc_mode_e mode_q;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= ENC_OUT;
        else     mode_q <= next_mode(mode_q, cmd);
    end

    assign optout = (mode_q == ENC_OPTOUT);

    p_exit_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd.leave && !cmd.enter) |=> !optout);

    p_entry_wins_r11: assert property (@(posedge clk) disable iff (rst)
        (cmd.enter && cmd.leave && cmd.optout) |=> optout);

    p_optin_free_r9: assert property (@(posedge clk) disable iff (rst)
        (cmd.enter && !cmd.optout) |=> !optout);

endmodule

// File: rtl/pmc_ctr.sv
module pmc_ctr
    import pmc_gate_pkg::*;
#(
    parameter int CNT_W = 48
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             own_evt,
    input  logic             sib_evt,
    input  logic             any_ok,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);

    logic [CNT_W:0] sum;

    always_comb begin
        sum = {1'b0, count};
        if (run) sum = {1'b0, count} + {{(CNT_W-1){1'b0}}, evt_incr(own_evt, sib_evt, any_ok)};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            count <= sum[CNT_W-1:0];
            ovf   <= sum[CNT_W];
        end
    end

    p_hold_when_gated_r1: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(count));

    p_demoted_sib_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (run && !any_ok && !own_evt) |=> $stable(count));

    p_wrap_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        ovf |-> (count < 2) && !$past(ovf));

endmodule

// File: rtl/pmc_sticky.sv
module pmc_sticky (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);

    always_ff @(posedge clk) begin
        if (rst) flag <= 1'b0;
        else     flag <= set | (flag & ~clr);
    end

    p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
        set |=> flag);

    p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);

    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !flag);

endmodule

// File: rtl/pmc_enclave_gate.sv
module pmc_enclave_gate
    import pmc_gate_pkg::*;
#(
    parameter int NUM_GP = 4,
    parameter int CNT_W  = 48
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             local_enter,
    input  logic                             local_enter_optout,
    input  logic                             local_exit,
    input  logic                             local_aex,
    input  logic                             sib_enter,
    input  logic                             sib_enter_optout,
    input  logic                             sib_exit,
    input  logic [NUM_GP-1:0]                gp_evt_own,
    input  logic [NUM_GP-1:0]                gp_evt_sib,
    input  logic [NUM_GP-1:0]                gp_anythr,
    input  logic [NUM_FIX-1:0]               fx_evt_own,
    input  logic [NUM_FIX-1:0]               fx_evt_sib,
    input  logic [NUM_FIX-1:0]               fx_anythr,
    input  logic                             status_clr,
    output logic [NUM_GP-1:0][CNT_W-1:0]     gp_count,
    output logic [NUM_FIX-1:0][CNT_W-1:0]    fx_count,
    output logic [NUM_GP-1:0]                gp_ovf,
    output logic [NUM_FIX-1:0]               fx_ovf,
    output logic                             sample_suppress,
    output logic [STATUS_W-1:0]              global_status
);

    enc_cmd_t local_cmd, sib_cmd;
    logic     local_optout, sib_optout;
    logic     supp_set, supp_flag;

    assign local_cmd = '{enter: local_enter, optout: local_enter_optout,
                         leave: local_exit | local_aex};
    assign sib_cmd   = '{enter: sib_enter, optout: sib_enter_optout,
                         leave: sib_exit};

    pmc_mode_track u_local (
        .clk(clk), .rst(rst), .cmd(local_cmd), .optout(local_optout)
    );

    pmc_mode_track u_sib (
        .clk(clk), .rst(rst), .cmd(sib_cmd), .optout(sib_optout)
    );

    // Suppressed after this edge: staying in opt-out or entering opt-out now.
    assign supp_set = (local_enter & local_enter_optout) |
                      (local_optout & ~local_enter & ~local_cmd.leave);

    pmc_sticky u_status (
        .clk(clk), .rst(rst), .set(supp_set), .clr(status_clr), .flag(supp_flag)
    );

    assign sample_suppress = local_optout;

    always_comb begin
        global_status           = '0;
        global_status[SUPP_BIT] = supp_flag;
    end

    for (genvar g = 0; g < NUM_GP; g++) begin : g_gp
        pmc_ctr #(.CNT_W(CNT_W)) u_ctr (
            .clk(clk), .rst(rst),
            .run(~local_optout),
            .own_evt(gp_evt_own[g]),
            .sib_evt(gp_evt_sib[g]),
            .any_ok(gp_anythr[g] & ~sib_optout),
            .count(gp_count[g]),
            .ovf(gp_ovf[g])
        );
    end

    for (genvar f = 0; f < NUM_FIX; f++) begin : g_fx
        logic fx_run;
        if (f == 0) begin : g_gated
            assign fx_run = ~local_optout;
        end else begin : g_cycles
            assign fx_run = 1'b1;
        end
        pmc_ctr #(.CNT_W(CNT_W)) u_ctr (
            .clk(clk), .rst(rst),
            .run(fx_run),
            .own_evt(fx_evt_own[f]),
            .sib_evt(fx_evt_sib[f]),
            .any_ok(fx_anythr[f] & ~sib_optout),
            .count(fx_count[f]),
            .ovf(fx_ovf[f])
        );
    end

    p_suppress_origin_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(sample_suppress) |-> $past(local_enter && local_enter_optout));

    p_status_tracks_r4: assert property (@(posedge clk) disable iff (rst)
        sample_suppress |-> global_status[SUPP_BIT]);

    p_cycles_run_r2: assert property (@(posedge clk) disable iff (rst)
        (sample_suppress && fx_evt_own[1]) |=> fx_count[1] != $past(fx_count[1]));

endmodule

// File: tb/pmc_enclave_gate_bench.sv
module pmc_enclave_gate_bench;
    import pmc_gate_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NG = 4;
    localparam int W  = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic local_enter = 0, local_enter_optout = 0, local_exit = 0, local_aex = 0;
    logic sib_enter = 0, sib_enter_optout = 0, sib_exit = 0;
    logic [NG-1:0] gp_evt_own = '0, gp_evt_sib = '0, gp_anythr = '0;
    logic [2:0]    fx_evt_own = '0, fx_evt_sib = '0, fx_anythr = '0;
    logic status_clr = 0;
    logic [NG-1:0][W-1:0] gp_count;
    logic [2:0][W-1:0]    fx_count;
    logic [NG-1:0] gp_ovf;
    logic [2:0]    fx_ovf;
    logic sample_suppress;
    logic [63:0] global_status;

    int n_checks = 0;
    int n_fail   = 0;
    logic [NG-1:0][W-1:0] gp_base;
    logic [2:0][W-1:0]    fx_base;

    always #(CLK_PERIOD/2) clk = ~clk;

    pmc_enclave_gate #(.NUM_GP(NG), .CNT_W(W)) u_pmc_enclave_gate (
        .clk(clk), .rst(rst),
        .local_enter(local_enter), .local_enter_optout(local_enter_optout),
        .local_exit(local_exit), .local_aex(local_aex),
        .sib_enter(sib_enter), .sib_enter_optout(sib_enter_optout), .sib_exit(sib_exit),
        .gp_evt_own(gp_evt_own), .gp_evt_sib(gp_evt_sib), .gp_anythr(gp_anythr),
        .fx_evt_own(fx_evt_own), .fx_evt_sib(fx_evt_sib), .fx_anythr(fx_anythr),
        .status_clr(status_clr),
        .gp_count(gp_count), .fx_count(fx_count), .gp_ovf(gp_ovf), .fx_ovf(fx_ovf),
        .sample_suppress(sample_suppress), .global_status(global_status)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic snap();
        gp_base = gp_count;
        fx_base = fx_count;
    endtask

    task automatic events(input int n, input logic [NG-1:0] go, input logic [NG-1:0] gs,
                          input logic [2:0] fo, input logic [2:0] fs);
        for (int i = 0; i < n; i++) begin
            gp_evt_own = go; gp_evt_sib = gs; fx_evt_own = fo; fx_evt_sib = fs;
            tick();
        end
        gp_evt_own = '0; gp_evt_sib = '0; fx_evt_own = '0; fx_evt_sib = '0;
    endtask

    task automatic enter_local(input logic opt);
        local_enter = 1; local_enter_optout = opt;
        tick();
        local_enter = 0; local_enter_optout = 0;
    endtask

    task automatic exit_local(input logic async_exit);
        if (async_exit) local_aex = 1; else local_exit = 1;
        tick();
        local_aex = 0; local_exit = 0;
    endtask

    task automatic t_reset();
        chk("R12 gp0", gp_count[0], 0);
        chk("R12 fx2", fx_count[2], 0);
        chk("R12 status", global_status, 0);
        chk("R12 suppress", sample_suppress, 0);
        chk("R12 ovf", {gp_ovf, fx_ovf}, 0);
    endtask

    task automatic t_optin();
        enter_local(1'b0);
        chk("R9 suppress", sample_suppress, 0);
        snap();
        events(3, '1, '0, '1, '0);
        chk("R9 gp1", gp_count[1] - gp_base[1], 3);
        chk("R9 fx0", fx_count[0] - fx_base[0], 3);
        chk("R9 status", global_status, 0);
        exit_local(1'b0);
    endtask

    task automatic t_optout();
        enter_local(1'b1);
        chk("R3 suppress on", sample_suppress, 1);
        chk("R4 status", global_status, 64'd1 << 60);
        snap();
        events(4, '1, '0, '1, '0);
        chk("R1 gp0 frozen", gp_count[0] - gp_base[0], 0);
        chk("R1 gp3 frozen", gp_count[3] - gp_base[3], 0);
        chk("R1 fx0 frozen", fx_count[0] - fx_base[0], 0);
        chk("R2 fx1 runs", fx_count[1] - fx_base[1], 4);
        chk("R2 fx2 runs", fx_count[2] - fx_base[2], 4);
        exit_local(1'b0);
        chk("R8 normal exit", sample_suppress, 0);
        snap();
        events(2, '1, '0, '1, '0);
        chk("R8 gp0 resumes", gp_count[0] - gp_base[0], 2);
        chk("R8 fx0 resumes", fx_count[0] - fx_base[0], 2);
        chk("R5 sticky", global_status[60], 1);
    endtask

    task automatic t_clear();
        status_clr = 1; tick(); status_clr = 0;
        chk("R5 clear", global_status, 0);
        local_enter = 1; local_enter_optout = 1; status_clr = 1;
        tick();
        local_enter = 0; local_enter_optout = 0; status_clr = 0;
        chk("R5 clear vs set", global_status[60], 1);
        status_clr = 1; tick(); status_clr = 0;
        chk("R5 clear while suppressed", global_status[60], 1);
        exit_local(1'b1);
        chk("R8 async exit", sample_suppress, 0);
        status_clr = 1; tick(); status_clr = 0;
        chk("R5 clear after exit", global_status, 0);
    endtask

    task automatic t_anythread();
        gp_anythr = 4'b0001; fx_anythr = 3'b010;
        snap();
        events(3, '1, '1, '1, '1);
        chk("R6 gp0 any", gp_count[0] - gp_base[0], 6);
        chk("R6 gp1 own", gp_count[1] - gp_base[1], 3);
        chk("R6 fx1 any", fx_count[1] - fx_base[1], 6);
        sib_enter = 1; sib_enter_optout = 1; tick(); sib_enter = 0; sib_enter_optout = 0;
        snap();
        events(3, '1, '1, '1, '1);
        chk("R7 gp0 demoted", gp_count[0] - gp_base[0], 3);
        chk("R7 fx1 demoted", fx_count[1] - fx_base[1], 3);
        chk("R7 local unaffected", sample_suppress, 0);
        sib_exit = 1; tick(); sib_exit = 0;
        snap();
        events(2, '1, '1, '0, '0);
        chk("R7 gp0 promoted", gp_count[0] - gp_base[0], 4);
        gp_anythr = '0; fx_anythr = '0;
    endtask

    task automatic t_same_cycle();
        enter_local(1'b0);
        local_enter = 1; local_enter_optout = 1; local_exit = 1;
        tick();
        local_enter = 0; local_enter_optout = 0; local_exit = 0;
        chk("R11 optout wins", sample_suppress, 1);
        local_enter = 1; local_enter_optout = 0; local_aex = 1;
        tick();
        local_enter = 0; local_aex = 0;
        chk("R11 optin wins", sample_suppress, 0);
        snap();
        events(1, '1, '0, '0, '0);
        chk("R11 gp2 counts", gp_count[2] - gp_base[2], 1);
        exit_local(1'b0);
    endtask

    task automatic t_wrap();
        int need;
        need = 255 - int'(gp_count[2]);
        events(need, 4'b0100, '0, '0, '0);
        chk("R10 at max", gp_count[2], 255);
        chk("R10 no early ovf", gp_ovf[2], 0);
        events(1, 4'b0100, '0, '0, '0);
        chk("R10 wrapped", gp_count[2], 0);
        chk("R10 ovf pulse", gp_ovf[2], 1);
        tick();
        chk("R10 ovf one cycle", gp_ovf[2], 0);
    endtask

    initial begin
        fork
            begin
                repeat (3) tick();
                rst = 0;
                t_reset();
                t_optin();
                t_optout();
                t_clear();
                t_anythread();
                t_same_cycle();
                t_wrap();
            end
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule